// File: doc/BRIEF.md
# Full-Bridge Dead-Time Sequencer

This block converts two logic-level PWM inputs into the four gate commands of a full bridge. The bridge has two legs. In each leg, an active-low gate drives a high-side P-channel switch, and an active-high gate drives a low-side N-channel switch. The two legs are independent, and each follows only its own PWM input. When a PWM level changes, the leg first turns off the device that is conducting. It then waits a fixed non-overlap interval before it turns on the other device. The interval differs by direction. Both intervals, and the propagation delay before the first edge, are parameters counted in clock cycles.

The block also has a protective override. It drives every output to the safe state while the supply-good input is low. It does the same while a latched over-temperature flag is set. In the safe state every P gate is high and every N gate is low. The flag sets when the signed temperature code rises above an upper limit. It clears only when the code falls below a lower limit. When the override releases, each leg starts from both devices off and waits a full non-overlap interval before it turns anything on. Each PWM input is first passed through a two-stage synchronizer. The supply-good input and the temperature code are taken as synchronous to the clock.

Top module: `fbd_seq_top`

## Requirements
- R1: While rst_n is low, every P gate output is 1 and every N gate output is 0.
- R2: A 0-to-1 change on a leg's PWM makes its P gate go from 0 to 1 on the (TP_CYC+3)th rising clock edge after the change. The three extra edges are two synchronizer stages and one decision edge. The N gate then goes from 0 to 1 exactly TD_RISE_CYC edges after the P gate edge.
- R3: A 1-to-0 change on a leg's PWM makes its N gate go from 1 to 0 on the (TP_CYC+3)th rising edge. The P gate then goes from 1 to 0 exactly TD_FALL_CYC edges later.
- R4: The two legs are independent. A change on pwm1 never moves pgate2 or ngate2, and a change on pwm2 never moves pgate1 or ngate1.
- R5: A PWM excursion that returns to its old level before the first output edge is dropped. For example, a one-cycle pulse with TP_CYC of 2 is dropped, and neither gate of that leg moves.
- R6: If the PWM level reverses while a leg has both devices off and is waiting to turn one on, that turn-on is cancelled. The leg then turns on the other device a full interval after the reversal is seen. This is the third rising edge after the input change, and the interval is TD_FALL_CYC for turning the high side on and TD_RISE_CYC for turning the low side on.
- R7: No leg ever has its P gate at 0 and its N gate at 1 together. An N gate rises only at least TD_RISE_CYC edges after its P gate last rose. A P gate falls only at least TD_FALL_CYC edges after its N gate last fell.
- R8: One rising edge after supply_ok is sampled low, every P gate is 1 and every N gate is 0. The outputs stay there while supply_ok remains low.
- R9: When the override releases, a leg turns on a device a full interval after the first edge at which the override is clear. That interval is TD_RISE_CYC if the PWM is 1 (N gate rises) and TD_FALL_CYC if the PWM is 0 (P gate falls).
- R10: temp_code is a two's complement value in degrees. A value strictly above T_HOT (default 150) sets the over-temperature flag at the next edge, and the outputs become safe one edge later. A value equal to T_HOT, or any negative value, does not set it.
- R11: The flag stays set while temp_code is at or above T_COOL (default 110). It clears at the edge after a value below T_COOL is seen, and the legs then restart as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm1 | input | 1 | PWM command for leg 1 (1 = low side on) |
| pwm2 | input | 1 | PWM command for leg 2 (1 = low side on) |
| supply_ok | input | 1 | Supply good; 0 forces the safe state |
| temp_code | input | TEMP_W | Signed die temperature in degrees |
| pgate1 | output | 1 | Leg 1 high-side gate, 0 = on |
| ngate1 | output | 1 | Leg 1 low-side gate, 1 = on |
| pgate2 | output | 1 | Leg 2 high-side gate, 0 = on |
| ngate2 | output | 1 | Leg 2 low-side gate, 1 = on |

## Verification
The bench uses different rise and fall intervals, so a design that swaps them is caught. It measures the exact edge at which each gate moves.

A one-cycle PWM glitch targets the cancel path; a design that commits early would let the P gate bounce. A reversal in the middle of the dead time targets the restart path; a leg that resumed the old count would turn the low side on, or would turn the high side on too early.

Temperatures of exactly 150 and 110 probe the hysteresis boundaries, where an off-by-one comparison would trip or release at the wrong point, and a negative code catches unsigned compares.

Random PWM and supply activity, watched every cycle for shoot-through and short gaps, catches a release from the safe state that skips the full interval.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  // Leg sequencer states. PROP_* keep the old device on while the
  // propagation count runs; WAIT_* have both devices off.
  typedef enum logic [2:0] {
    LS_SAFE    = 3'd0,
    LS_HI_ON   = 3'd1,
    LS_PROP_LO = 3'd2,
    LS_WAIT_LO = 3'd3,
    LS_LO_ON   = 3'd4,
    LS_PROP_HI = 3'd5,
    LS_WAIT_HI = 3'd6
  } leg_st_e;

  // Gate levels for a state: {pgate, ngate}
  function automatic logic [1:0] gates_of(leg_st_e s);
    case (s)
      LS_HI_ON, LS_PROP_LO: gates_of = 2'b00;
      LS_LO_ON, LS_PROP_HI: gates_of = 2'b11;
      default:              gates_of = 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/fbd_sync.sv
module fbd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/fbd_thermal.sv
module fbd_thermal #(
  parameter int TEMP_W = 9,
  parameter int T_HOT  = 150,
  parameter int T_COOL = 110
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [TEMP_W-1:0] temp_code,
  output logic                     hot
);
  localparam logic signed [TEMP_W-1:0] HOT_C  = TEMP_W'(T_HOT);
  localparam logic signed [TEMP_W-1:0] COOL_C = TEMP_W'(T_COOL);

  always_ff @(posedge clk) begin
    if (!rst_n)                hot <= 1'b0;
    else if (temp_code > HOT_C) hot <= 1'b1;
    else if (temp_code < COOL_C) hot <= 1'b0;
  end

  // R10
  hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > HOT_C) |=> hot);

  // R11
  hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && temp_code >= COOL_C) |=> hot);
endmodule

// File: rtl/fbd_leg.sv
module fbd_leg
  import fbd_pkg::*;
#(
  parameter int TD_RISE_CYC = 35,
  parameter int TD_FALL_CYC = 35,
  parameter int TP_CYC      = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_off,
  input  logic pwm_s,
  output logic pgate,
  output logic ngate
);
  localparam int MAXD = (TD_RISE_CYC > TD_FALL_CYC) ?
                        ((TD_RISE_CYC > TP_CYC) ? TD_RISE_CYC : TP_CYC) :
                        ((TD_FALL_CYC > TP_CYC) ? TD_FALL_CYC : TP_CYC);
  localparam int CW = $clog2(MAXD + 1);
  localparam logic [CW-1:0] RISE_L = CW'(TD_RISE_CYC - 1);
  localparam logic [CW-1:0] FALL_L = CW'(TD_FALL_CYC - 1);
  localparam logic [CW-1:0] PROP_L = CW'(TP_CYC - 1);

  leg_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    gt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (force_off) begin
      st_d  = LS_SAFE;
      cnt_d = '0;
    end else begin
      case (st_q)
        LS_SAFE: begin
          st_d  = pwm_s ? LS_WAIT_LO : LS_WAIT_HI;
          cnt_d = pwm_s ? RISE_L : FALL_L;
        end
        LS_HI_ON: if (pwm_s) begin
          st_d  = LS_PROP_LO;
          cnt_d = PROP_L;
        end
        LS_PROP_LO: begin
          if (!pwm_s)            st_d = LS_HI_ON;
          else if (cnt_q == '0) begin
            st_d  = LS_WAIT_LO;
            cnt_d = RISE_L;
          end else               cnt_d = cnt_q - 1'b1;
        end
        LS_WAIT_LO: begin
          if (!pwm_s) begin
            st_d  = LS_WAIT_HI;
            cnt_d = FALL_L;
          end else if (cnt_q == '0) st_d = LS_LO_ON;
          else                      cnt_d = cnt_q - 1'b1;
        end
        LS_LO_ON: if (!pwm_s) begin
          st_d  = LS_PROP_HI;
          cnt_d = PROP_L;
        end
        LS_PROP_HI: begin
          if (pwm_s)             st_d = LS_LO_ON;
          else if (cnt_q == '0) begin
            st_d  = LS_WAIT_HI;
            cnt_d = FALL_L;
          end else               cnt_d = cnt_q - 1'b1;
        end
        LS_WAIT_HI: begin
          if (pwm_s) begin
            st_d  = LS_WAIT_LO;
            cnt_d = RISE_L;
          end else if (cnt_q == '0) st_d = LS_HI_ON;
          else                      cnt_d = cnt_q - 1'b1;
        end
        default: begin
          st_d  = LS_SAFE;
          cnt_d = '0;
        end
      endcase
    end
  end

  assign gt_d = gates_of(st_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LS_SAFE;
      cnt_q <= '0;
      pgate <= 1'b1;
      ngate <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      pgate <= gt_d[1];
      ngate <= gt_d[0];
    end
  end

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pgate && ngate));

  // R7
  n_after_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ngate) |-> $past(pgate));

  // R7
  p_after_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgate) |-> !$past(ngate));

  // R8
  safe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (pgate && !ngate));
endmodule

// File: rtl/fbd_seq_top.sv
module fbd_seq_top #(
  parameter int TD_RISE_CYC = 35,
  parameter int TD_FALL_CYC = 35,
  parameter int TP_CYC      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int TEMP_W      = 9,
  parameter int T_HOT       = 150,
  parameter int T_COOL      = 110
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwm1,
  input  logic                     pwm2,
  input  logic                     supply_ok,
  input  logic signed [TEMP_W-1:0] temp_code,
  output logic                     pgate1,
  output logic                     ngate1,
  output logic                     pgate2,
  output logic                     ngate2
);
  localparam int NLEG = 2;

  logic [NLEG-1:0] pwm_raw, pwm_s, pg, ng;
  logic            hot, force_off;

  assign pwm_raw   = {pwm2, pwm1};
  assign force_off = !supply_ok || hot;

  fbd_thermal #(
    .TEMP_W (TEMP_W),
    .T_HOT  (T_HOT),
    .T_COOL (T_COOL)
  ) u_therm (
    .clk       (clk),
    .rst_n     (rst_n),
    .temp_code (temp_code),
    .hot       (hot)
  );

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      fbd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pwm_raw[g]),
        .q     (pwm_s[g])
      );
      fbd_leg #(
        .TD_RISE_CYC (TD_RISE_CYC),
        .TD_FALL_CYC (TD_FALL_CYC),
        .TP_CYC      (TP_CYC)
      ) u_leg (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_off (force_off),
        .pwm_s     (pwm_s[g]),
        .pgate     (pg[g]),
        .ngate     (ng[g])
      );
    end
  endgenerate

  assign pgate1 = pg[0];
  assign ngate1 = ng[0];
  assign pgate2 = pg[1];
  assign ngate2 = ng[1];
endmodule

// File: tb/tb_fbd_seq_top.sv
module tb_fbd_seq_top;
  localparam int CLK_NS = 10;
  localparam int TD1 = 7;
  localparam int TD2 = 5;
  localparam int TP  = 2;
  localparam int FIRST = TP + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm1 = 1'b0, pwm2 = 1'b0, supply_ok = 1'b1;
  logic signed [8:0] temp_code = 9'sd25;
  logic pgate1, ngate1, pgate2, ngate2;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  logic cap [4][0:63];
  logic [1:0] pg_w, ng_w, pg_prev, ng_prev;
  int p_off_t [2], n_off_t [2];

  fbd_seq_top #(
    .TD_RISE_CYC (TD1),
    .TD_FALL_CYC (TD2),
    .TP_CYC      (TP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .pwm1 (pwm1), .pwm2 (pwm2),
    .supply_ok (supply_ok), .temp_code (temp_code),
    .pgate1 (pgate1), .ngate1 (ngate1), .pgate2 (pgate2), .ngate2 (ngate2)
  );

  always #(CLK_NS/2) clk = ~clk;

  assign pg_w = {pgate2, pgate1};
  assign ng_w = {ngate2, ngate1};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic capture(input int n);
    cap[0][0] = pgate1; cap[1][0] = ngate1; cap[2][0] = pgate2; cap[3][0] = ngate2;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      cap[0][i] = pgate1; cap[1][i] = ngate1; cap[2][i] = pgate2; cap[3][i] = ngate2;
    end
  endtask

  // index of the first captured edge whose value differs from index 0; 0 = none
  function automatic int first_change(input int ch, input int n);
    for (int i = 1; i <= n; i++)
      if (cap[ch][i] !== cap[ch][0]) return i;
    return 0;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // every-cycle safety monitor (R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      for (int l = 0; l < 2; l++) begin
        total++;
        if (!pg_w[l] && ng_w[l]) begin
          bad++;
          $display("FAIL R7 shoot-through leg%0d act=p%0b n%0b exp=not p0 n1", l + 1, pg_w[l], ng_w[l]);
        end
        if (!pg_prev[l] && pg_w[l]) p_off_t[l] = cyc;
        if (ng_prev[l] && !ng_w[l]) n_off_t[l] = cyc;
        if (pg_prev[l] && !pg_w[l]) begin
          total++;
          if (cyc - n_off_t[l] < TD2) begin
            bad++;
            $display("FAIL R7 P on gap leg%0d act=%0d exp>=%0d", l + 1, cyc - n_off_t[l], TD2);
          end
        end
        if (!ng_prev[l] && ng_w[l]) begin
          total++;
          if (cyc - p_off_t[l] < TD1) begin
            bad++;
            $display("FAIL R7 N on gap leg%0d act=%0d exp>=%0d", l + 1, cyc - p_off_t[l], TD1);
          end
        end
      end
      pg_prev = pg_w;
      ng_prev = ng_w;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    pg_prev = 2'b11; ng_prev = 2'b00;
    p_off_t = '{0, 0}; n_off_t = '{0, 0};
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pgate1", pgate1, 1); chk("R1 ngate1", ngate1, 0);
    chk("R1 pgate2", pgate2, 1); chk("R1 ngate2", ngate2, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9 idle high side on p1", pgate1, 0);

    // R2: rising PWM on leg 1
    pwm1 = 1'b1; capture(40);
    chk("R2 p1 off edge", first_change(0, 40), FIRST);
    chk("R2 n1 on edge", first_change(1, 40), FIRST + TD1);
    chk("R4 p2 still", first_change(2, 40), 0);
    chk("R4 n2 still", first_change(3, 40), 0);

    // R3: falling PWM on leg 1
    pwm1 = 1'b0; capture(40);
    chk("R3 n1 off edge", first_change(1, 40), FIRST);
    chk("R3 p1 on edge", first_change(0, 40), FIRST + TD2);

    // R4: leg 2 alone
    pwm2 = 1'b1; capture(40);
    chk("R4 p2 off edge", first_change(2, 40), FIRST);
    chk("R4 n2 on edge", first_change(3, 40), FIRST + TD1);
    chk("R4 p1 still", first_change(0, 40), 0);
    chk("R4 n1 still", first_change(1, 40), 0);

    // R5: one-cycle glitch is dropped
    pwm1 = 1'b1; @(negedge clk); pwm1 = 1'b0; capture(30);
    chk("R5 p1 no move", first_change(0, 30), 0);
    chk("R5 n1 no move", first_change(1, 30), 0);

    // R6: reversal during dead time
    pwm1 = 1'b1;
    repeat (FIRST + 1) @(negedge clk);
    chk("R6 p1 off in dead", pgate1, 1);
    chk("R6 n1 off in dead", ngate1, 0);
    pwm1 = 1'b0; capture(30);
    chk("R6 p1 back on", first_change(0, 30), 3 + TD2);
    chk("R6 n1 never on", first_change(1, 30), 0);

    // R8: supply drop (leg1 high side on, leg2 low side on)
    supply_ok = 1'b0; capture(3);
    chk("R8 p1 forced off", first_change(0, 3), 1);
    chk("R8 n2 forced off", first_change(3, 3), 1);

    // R9: release with leg1 wanting low side, leg2 wanting high side
    pwm1 = 1'b1; pwm2 = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 held p1", pgate1, 1); chk("R8 held n1", ngate1, 0);
    supply_ok = 1'b1; capture(30);
    chk("R9 n1 after full wait", first_change(1, 30), 1 + TD1);
    chk("R9 p2 after full wait", first_change(2, 30), 1 + TD2);
    chk("R9 p1 unchanged", first_change(0, 30), 0);

    // R10: thermal trip threshold
    temp_code = 9'sd150; capture(10);
    chk("R10 at limit no trip n1", first_change(1, 10), 0);
    chk("R10 at limit no trip p2", first_change(2, 10), 0);
    temp_code = 9'sd151; capture(6);
    chk("R10 trip n1", first_change(1, 6), 2);
    chk("R10 trip p2", first_change(2, 6), 2);

    // R11: hysteresis
    temp_code = 9'sd120; capture(10);
    chk("R11 hold at 120", first_change(1, 10), 0);
    temp_code = 9'sd110; capture(20);
    chk("R11 hold at 110 n1", first_change(1, 20), 0);
    chk("R11 hold at 110 p2", first_change(2, 20), 0);
    temp_code = 9'sd109; capture(30);
    chk("R11 release n1", first_change(1, 30), 2 + TD1);
    chk("R11 release p2", first_change(2, 30), 2 + TD2);

    // R10: negative code is cold
    temp_code = -9'sd40; capture(10);
    chk("R10 negative no trip n1", first_change(1, 10), 0);
    chk("R10 negative no trip p2", first_change(2, 10), 0);
    temp_code = 9'sd25;

    // random phase, monitored for R7
    for (int it = 0; it < 600; it++) begin
      int hold;
      if ($urandom_range(0, 2) == 0) pwm1 = ~pwm1;
      if ($urandom_range(0, 2) == 0) pwm2 = ~pwm2;
      supply_ok = ($urandom_range(0, 19) != 0);
      hold = $urandom_range(1, 20);
      repeat (hold) @(negedge clk);
    end
    supply_ok = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 final leg1 matches pwm1", ngate1, pwm1);
    chk("R3 final leg2 matches pwm2", pgate2, pwm2);

    finish_run();
  end
endmodule